// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers the interrupt sources of a parallel-interface adapter style peripheral into one request line for the host. Seven sources (two timers, the shift register and four control-line edge detectors) deliver one-cycle set pulses. Each pulse latches a bit in a 7-bit flag register. A 7-bit enable register selects which pending flags count as interrupts. A byte-wide register port reads and writes both registers. Flags are cleared by writing ones to them, or as a side effect of reading the shift-register data address.

Writes to the enable register use bit 7 of the data as a mode bit. When bit 7 is set, the ones written are added to the enable set. When bit 7 is clear, the ones written are removed from it. On a read, bit 7 of the flag register is a live summary that any enabled flag is pending, and bit 7 of the enable register always reads as 1. The interrupt request output is registered and only the timer and shift-register sources drive it.

Top module: `irq_flag_ctl`

## Requirements
- R1: While reset is asserted and right after it, every flag and every enable is 0 and `irq` is low.
- R2: A high bit on `setPulse` for one cycle sets the matching flag. The bit positions are Timer 1 = 6, Timer 2 = 5, CB1 = 4, CB2 = 3, shift register = 2, CA1 = 1 and CA2 = 0.
- R3: A write to the flag register (address 0xD) clears every flag whose data bit is 1 and leaves the other flags unchanged.
- R4: A write to the enable register (address 0xE) with data bit 7 = 1 ORs data bits 6..0 into the enables.
- R5: A write to the enable register with data bit 7 = 0 clears every enable whose data bit is 1 and leaves the other enables unchanged.
- R6: A read of the enable register returns bit 7 = 1 and the enables in bits 6..0.
- R7: A read of the flag register returns the flags in bits 6..0. Bit 7 is 1 exactly when some flag (any of the seven) is set and also enabled.
- R8: `irq` can be high only when a flag that is also enabled is pending in bit 6, 5 or 2. Enabled pending flags in bits 4, 3, 1 and 0 do not raise it.
- R9: A read strobe at the shift-register data address (0xA) clears the flags in bits 4, 3 and 2 and leaves the others unchanged.
- R10: If a set pulse and a clearing access (flag write or shift-data read) hit the same flag in the same cycle, the flag ends up set.
- R11: `irq` is registered. It reflects the flags and enables as they stood after the previous clock edge, so it changes one cycle after the change that caused it.
- R12: `rdData` is combinational on `addr`. Any address other than 0xD or 0xE reads as 0x00. Reads have no side effect except the one in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (used only for read side effects) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` |
| setPulse | input | 7 | Flag set pulses from the sources |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a set pulse that arrives in the same cycle as an access that clears that same flag. It needs the source pulse and the bus access to be driven together. The stimulus table has entries that carry both a Timer 2 pulse with a flag write of that bit, and a shift-register pulse with a shift-data read. Other entries enable the control-line sources only. They check that the summary bit rises while `irq` stays low, which separates the two kinds of aggregation.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int SRC_N  = 7;
  localparam int DATA_W = 8;

  // Flag bit positions
  localparam int T1_BIT  = 6;
  localparam int T2_BIT  = 5;
  localparam int CB1_BIT = 4;
  localparam int CB2_BIT = 3;
  localparam int SR_BIT  = 2;
  localparam int CA1_BIT = 1;
  localparam int CA2_BIT = 0;

  localparam logic [SRC_N-1:0] IRQ_SRC_MASK =
    SRC_N'((1 << T1_BIT) | (1 << T2_BIT) | (1 << SR_BIT));
  localparam logic [SRC_N-1:0] SHIFT_RD_MASK =
    SRC_N'((1 << CB1_BIT) | (1 << CB2_BIT) | (1 << SR_BIT));

  typedef enum logic [1:0] {RD_NONE, RD_FLAG, RD_EN} rd_sel_e;

  typedef struct packed {
    logic [SRC_N-1:0] flagClr;
    logic [SRC_N-1:0] enSet;
    logic [SRC_N-1:0] enClr;
    rd_sel_e          rdSel;
  } strobe_t;
endpackage

// File: rtl/irq_ctl_decode.sv
module irq_ctl_decode
  import irq_ctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = ADDR_W'(4'hD),
  parameter logic [ADDR_W-1:0] EN_ADDR    = ADDR_W'(4'hE),
  parameter logic [ADDR_W-1:0] SHIFT_ADDR = ADDR_W'(4'hA)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strb
);
  logic flagHit, enHit, shiftHit;

  assign flagHit  = (addr == FLAG_ADDR);
  assign enHit    = (addr == EN_ADDR);
  assign shiftHit = (addr == SHIFT_ADDR);

  always_comb begin
    strb = '0;
    if (flagHit)    strb.rdSel = RD_FLAG;
    else if (enHit) strb.rdSel = RD_EN;
    else            strb.rdSel = RD_NONE;
    if (wrEn && flagHit) strb.flagClr = strb.flagClr | wrData[SRC_N-1:0];
    if (rdEn && shiftHit) strb.flagClr = strb.flagClr | SHIFT_RD_MASK;
    if (wrEn && enHit) begin
      if (wrData[DATA_W-1]) strb.enSet = wrData[SRC_N-1:0];
      else                  strb.enClr = wrData[SRC_N-1:0];
    end
  end

  // R9
  shift_rd_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && shiftHit) |-> ((strb.flagClr & SHIFT_RD_MASK) == SHIFT_RD_MASK));

  // R4
  set_mode_no_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && enHit && wrData[DATA_W-1]) |-> (strb.enClr == '0));
endmodule

// File: rtl/irq_ctl_datapath.sv
module irq_ctl_datapath
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [SRC_N-1:0]  setPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic [SRC_N-1:0] flags;
  logic [SRC_N-1:0] enables;
  logic [SRC_N-1:0] pending;

  // One cell per flag; a set in the same cycle overrides a clear
  for (genvar i = 0; i < SRC_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              flags[i] <= 1'b0;
      else if (setPulse[i])   flags[i] <= 1'b1;
      else if (strb.flagClr[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enables <= '0;
    else       enables <= (enables | strb.enSet) & ~strb.enClr;
  end

  assign pending = flags & enables;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(pending & IRQ_SRC_MASK);
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_FLAG: rdData = {|pending, flags};
      RD_EN:   rdData = {1'b1, enables};
      default: rdData = '0;
    endcase
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rstN |-> (flags == '0 && enables == '0 && !irq));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|setPulse) |=> ((flags & $past(setPulse)) == $past(setPulse)));

  // R3
  clear_applies_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.flagClr) |=> ((flags & $past(strb.flagClr & ~setPulse)) == '0));

  // R4
  enable_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.enSet) |=> ((enables & $past(strb.enSet)) == $past(strb.enSet)));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|(enables & IRQ_SRC_MASK)) |=> !irq);

  // R11
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(flags & enables & IRQ_SRC_MASK)) |=> irq);
endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl
  import irq_ctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = ADDR_W'(4'hD),
  parameter logic [ADDR_W-1:0] EN_ADDR    = ADDR_W'(4'hE),
  parameter logic [ADDR_W-1:0] SHIFT_ADDR = ADDR_W'(4'hA)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [6:0]        setPulse,
  output logic              irq
);
  strobe_t strb;

  irq_ctl_decode #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR),
    .EN_ADDR(EN_ADDR), .SHIFT_ADDR(SHIFT_ADDR)
  ) i_decode (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .strb(strb)
  );

  irq_ctl_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .setPulse(setPulse),
    .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/test_irq_flag_ctl.sv
module test_irq_flag_ctl;
  localparam logic [3:0] A_FLAG  = 4'hD;
  localparam logic [3:0] A_EN    = 4'hE;
  localparam logic [3:0] A_SHIFT = 4'hA;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [3:0] addr;
    logic [7:0] data;
    logic [6:0] pulse;
    logic [7:0] expFlag;
    logic [7:0] expEn;
    logic       expIrq;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, A_FLAG,  8'h00, 7'h40, 8'h40, 8'h80, 1'b0}, // R2 T1 flag, nothing enabled
    '{1'b1, 1'b0, A_EN,    8'hC0, 7'h00, 8'hC0, 8'hC0, 1'b1}, // R4 enable T1
    '{1'b1, 1'b0, A_EN,    8'h86, 7'h00, 8'hC0, 8'hC6, 1'b1}, // R4 OR in SR, CA1
    '{1'b1, 1'b0, A_FLAG,  8'h40, 7'h00, 8'h00, 8'hC6, 1'b0}, // R3 clear T1
    '{1'b0, 1'b0, A_FLAG,  8'h00, 7'h02, 8'h82, 8'hC6, 1'b0}, // R7 R8 CA1 summary, no irq
    '{1'b1, 1'b0, A_EN,    8'h42, 7'h00, 8'h02, 8'h84, 1'b0}, // R5 clear enables 6,1
    '{1'b0, 1'b0, A_FLAG,  8'h00, 7'h1C, 8'h9E, 8'h84, 1'b1}, // R2 CB1 CB2 SR
    '{1'b0, 1'b1, A_SHIFT, 8'h00, 7'h00, 8'h02, 8'h84, 1'b0}, // R9 shift read clears
    '{1'b1, 1'b0, A_EN,    8'hA0, 7'h20, 8'hA2, 8'hA4, 1'b1}, // R2 R4 T2 pulse + enable
    '{1'b1, 1'b0, A_FLAG,  8'h20, 7'h20, 8'hA2, 8'hA4, 1'b1}, // R10 set beats W1C
    '{1'b1, 1'b0, A_FLAG,  8'hFF, 7'h00, 8'h00, 8'hA4, 1'b0}, // R3 clear all
    '{1'b0, 1'b1, A_SHIFT, 8'h00, 7'h04, 8'h84, 8'hA4, 1'b1}, // R10 set beats shift read
    '{1'b1, 1'b0, A_EN,    8'h7F, 7'h00, 8'h04, 8'h80, 1'b0}, // R5 R6 clear all enables
    '{1'b1, 1'b0, A_FLAG,  8'h04, 7'h00, 8'h00, 8'h80, 1'b0}  // R3 clear SR
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] addr = A_FLAG;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [6:0] setPulse = '0;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_flag_ctl i_irq_flag_ctl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .setPulse(setPulse), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 1'b0; rdEn = 1'b0; setPulse = '0; addr = A_FLAG; wrData = '0;
  endtask

  task automatic peek(input string req, input logic [7:0] expF,
                      input logic [7:0] expE, input logic expI);
    addr = A_FLAG; #1;
    chk({req, " flag read"}, rdData, expF);
    chk({req, " irq"}, {7'b0, irq}, {7'b0, expI});
    addr = A_EN; #1;
    chk({req, " enable read"}, rdData, expE);
    addr = A_FLAG;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    peek("R1 R6 in reset", 8'h00, 8'h80, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    peek("R1 after reset", 8'h00, 8'h80, 1'b0);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      addr = VECS[k].addr; wrEn = VECS[k].wr; rdEn = VECS[k].rd;
      wrData = VECS[k].data; setPulse = VECS[k].pulse;
      @(negedge clk);
      idle();
      @(negedge clk);
      peek($sformatf("R2/R3/R7/R8 vec%0d", k), VECS[k].expFlag, VECS[k].expEn, VECS[k].expIrq);
    end

    // R12 unmapped address reads 0, and a flag read has no side effect
    @(negedge clk);
    setPulse = 7'h40; wrEn = 1'b1; addr = A_EN; wrData = 8'hC0;
    @(negedge clk);
    idle();
    addr = 4'h3; #1;
    chk("R12 unmapped read", rdData, 8'h00);
    // R11 latency: flag set at previous edge, irq not yet high
    chk("R11 irq one cycle late", {7'b0, irq}, 8'h00);
    addr = A_FLAG; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; #1;
    chk("R11 irq high next cycle", {7'b0, irq}, 8'h01);
    chk("R12 flag read keeps flags", rdData, 8'hC0);

    // R1 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    peek("R1 mid-run reset", 8'h00, 8'h80, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule